// File: doc/BRIEF.md
# Security Policy Configuration CSR

This block is a machine-level control and status register that holds three global memory-protection policy bits: lockdown, whitelist and rule-lock bypass. Software accesses it through a plain CSR port made of an address, a privilege level, a write enable, write data and combinational read data. The block drives the three bits to the permission checker and to the entry configuration logic.

Two of the bits are sticky. After lockdown or whitelist becomes 1, only a reset clears it again. The bypass bit can go from 0 to 1 only while none of the protection entries has its lock bit set. The block samples a vector of those lock bits for this purpose. An upper-half companion register exists only when XLEN is 32. It reads as zero, and writes to it change nothing. The block does not raise traps. It only tells the core whether the current address is a defined CSR at the current privilege.

Top module: `sec_policy_csr`

## Requirements
- R1: After reset all three policy outputs are 0, and a read of 0x747 returns 0.
- R2: A write to 0x747 at machine privilege (csr_priv == 2'b11) uses only data bits 2:0: bit 0 is lockdown, bit 1 is whitelist and bit 2 is bypass. Data bits above bit 2 have no effect. A read of 0x747 returns bypass, whitelist and lockdown in bits 2, 1 and 0, with zeros in all higher bits.
- R3: Once lockdown is 1, it stays 1 until reset. A write can set it but cannot clear it.
- R4: Once whitelist is 1, it stays 1 until reset. A write can set it but cannot clear it.
- R5: A write can change bypass from 0 to 1 only when every bit of entry_lock (entries 0 to 15) is 0. When any lock bit is 1, bypass stays 0.
- R6: A write that tries to clear a bypass bit that is already 1 has no effect.
- R7: Writes to 0x757 are ignored and change none of the policy bits. A read of 0x757 returns 0.
- R8: csr_defined is 1 for 0x747 only at machine privilege. It is 1 for 0x757 only at machine privilege and only when XLEN is 32. It is 0 for every other address.
- R9: A write changes no state when csr_we is 0, when the address is not 0x747, or when the privilege is not machine.
- R10: The policy outputs and the read data change on the first rising clock edge after the write is presented, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address |
| csr_priv | input | 2 | Current privilege level (2'b11 = machine) |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| csr_defined | output | 1 | Address is a defined CSR at this privilege |
| entry_lock | input | NUM_ENTRIES | Lock bits of all protection entries |
| pol_lockdown | output | 1 | Machine lockdown policy bit |
| pol_whitelist | output | 1 | Machine whitelist policy bit |
| pol_bypass | output | 1 | Rule-lock bypass bit |

## Verification
The assertions assume that entry_lock, csr_priv and csr_addr are stable across each rising edge and are never X once reset is released. The bench meets this by changing every input only on the falling edge. The bypass property assumes the lock vector the block sees is the one that applies to the write. The stimulus therefore sets entry_lock together with the write data and holds it until the edge has passed. Privilege values cover all four encodings, so the decode and the write gating are both exercised off the machine level.

// File: rtl/sec_policy_pkg.sv
// Package: shared types and constants for the security policy CSR.
// Assumes the machine privilege encoding is 2'b11.
package sec_policy_pkg;

    // Policy bits in register order: bit 2 bypass, bit 1 whitelist, bit 0 lockdown
    typedef struct packed {
        logic bypass;
        logic whitelist;
        logic lockdown;
    } sec_bits_t;

    localparam int unsigned POL_W        = $bits(sec_bits_t);
    localparam logic [1:0]  PRIV_MACHINE = 2'b11;

endpackage

// File: rtl/secpol_addr_dec.sv
// Address decoder: flags hits on the main and upper-half addresses and
// reports whether the address is defined at the current privilege.
// Assumes the upper half exists only when HAS_HI is 1.
module secpol_addr_dec #(
    parameter int unsigned     ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] MAIN_ADDR = 12'h747,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 12'h757,
    parameter bit              HAS_HI    = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        priv,
    output logic              hit_main,
    output logic              hit_hi,
    output logic              defined
);
    import sec_policy_pkg::*;

    logic is_machine;

    // Compare address and privilege, and combine them into the defined flag
    always_comb begin
        is_machine = (priv == PRIV_MACHINE);
        hit_main   = (addr == MAIN_ADDR);
        hit_hi     = HAS_HI && (addr == HI_ADDR);
        defined    = is_machine && (hit_main || hit_hi);
    end

endmodule

// File: rtl/secpol_sticky_reg.sv
// Policy bit storage: lockdown and whitelist are set-only, and bypass may
// rise only while no entry lock is set and is then never cleared by a write.
// Assumes wr_en is already qualified by address and privilege.
module secpol_sticky_reg #(
    parameter int unsigned NUM_ENTRIES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  sec_policy_pkg::sec_bits_t   wr_bits,
    input  logic [NUM_ENTRIES-1:0]      entry_lock,
    output sec_policy_pkg::sec_bits_t   q
);
    import sec_policy_pkg::*;

    sec_bits_t nxt;
    logic      any_locked;

    // Work out the next value of each bit from its set-only rule
    always_comb begin
        any_locked    = |entry_lock;
        nxt           = q;
        if (wr_en) begin
            nxt.lockdown  = q.lockdown  | wr_bits.lockdown;
            nxt.whitelist = q.whitelist | wr_bits.whitelist;
            nxt.bypass    = q.bypass    | (wr_bits.bypass & ~any_locked);
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

endmodule

// File: rtl/secpol_rd_mux.sv
// Read data multiplexer: returns the policy bits, zero-extended, for the
// main address and zero for the upper half and all other addresses.
module secpol_rd_mux #(
    parameter int unsigned XLEN = 32
) (
    input  logic                      hit_main,
    input  sec_policy_pkg::sec_bits_t cur,
    output logic [XLEN-1:0]           rdata
);
    import sec_policy_pkg::*;

    // Select the zero-extended policy bits or zero
    always_comb begin
        rdata = '0;
        if (hit_main) rdata[POL_W-1:0] = cur;
    end

endmodule

// File: rtl/sec_policy_csr.sv
// Top: security policy CSR with sticky bits and the lock-gated bypass bit.
// Assumes inputs are synchronous to clk. Traps are raised elsewhere,
// using csr_defined.
module sec_policy_csr #(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned ADDR_W      = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      csr_addr,
    input  logic [1:0]             csr_priv,
    input  logic                   csr_we,
    input  logic [XLEN-1:0]        csr_wdata,
    output logic [XLEN-1:0]        csr_rdata,
    output logic                   csr_defined,
    input  logic [NUM_ENTRIES-1:0] entry_lock,
    output logic                   pol_lockdown,
    output logic                   pol_whitelist,
    output logic                   pol_bypass
);
    import sec_policy_pkg::*;

    localparam logic [ADDR_W-1:0] MAIN_ADDR = ADDR_W'(12'h747);
    localparam logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'(12'h757);
    localparam bit                HAS_HI    = (XLEN == 32);

    logic      hit_main;
    logic      hit_hi;
    logic      wr_en;
    sec_bits_t wr_bits;
    sec_bits_t cur;

    secpol_addr_dec #(
        .ADDR_W(ADDR_W), .MAIN_ADDR(MAIN_ADDR), .HI_ADDR(HI_ADDR), .HAS_HI(HAS_HI)
    ) u_dec (
        .addr(csr_addr), .priv(csr_priv),
        .hit_main(hit_main), .hit_hi(hit_hi), .defined(csr_defined)
    );

    // Qualify the write and keep only the low field bits of the data
    always_comb begin
        wr_en   = csr_we && hit_main && (csr_priv == PRIV_MACHINE);
        wr_bits = sec_bits_t'(csr_wdata[POL_W-1:0]);
    end

    secpol_sticky_reg #(.NUM_ENTRIES(NUM_ENTRIES)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bits(wr_bits),
        .entry_lock(entry_lock), .q(cur)
    );

    secpol_rd_mux #(.XLEN(XLEN)) u_rd (
        .hit_main(hit_main), .cur(cur), .rdata(csr_rdata)
    );

    // Drive the policy outputs from the stored bits
    always_comb begin
        pol_lockdown  = cur.lockdown;
        pol_whitelist = cur.whitelist;
        pol_bypass    = cur.bypass;
    end

endmodule

// File: rtl/secpol_chk.sv
// Checker: temporal properties of the policy CSR, bound to the top module.
module secpol_chk #(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned ADDR_W      = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      csr_addr,
    input logic [1:0]             csr_priv,
    input logic                   csr_we,
    input logic [XLEN-1:0]        csr_rdata,
    input logic [NUM_ENTRIES-1:0] entry_lock,
    input logic                   pol_lockdown,
    input logic                   pol_whitelist,
    input logic                   pol_bypass
);
    localparam logic [ADDR_W-1:0] MAIN_A = ADDR_W'(12'h747);
    localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(12'h757);

    // R3
    lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_lockdown |=> pol_lockdown);
    // R4
    whitelist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_whitelist |=> pol_whitelist);
    // R6
    bypass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_bypass |=> pol_bypass);
    // R5
    bypass_lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_bypass && (|entry_lock)) |=> !pol_bypass);
    // R9
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && csr_addr == MAIN_A && csr_priv == 2'b11)
        |=> $stable({pol_bypass, pol_whitelist, pol_lockdown}));
    // R7
    hi_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == HI_A) |-> (csr_rdata == '0));
    // R2
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[XLEN-1:3] == '0);

endmodule

bind sec_policy_csr secpol_chk #(
    .XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_priv(csr_priv),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .entry_lock(entry_lock),
    .pol_lockdown(pol_lockdown), .pol_whitelist(pol_whitelist),
    .pol_bypass(pol_bypass)
);

// File: tb/sim_sec_policy_csr.sv
// Bench: sweeps start states, write data and lock patterns against a model.
module sim_sec_policy_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h0;
    logic [1:0]  csr_priv = 2'b11;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = 32'h0;
    logic [31:0] csr_rdata;
    logic        csr_defined;
    logic [15:0] entry_lock = 16'h0;
    logic        pol_lockdown, pol_whitelist, pol_bypass;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sec_policy_csr u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_priv(csr_priv),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_defined(csr_defined), .entry_lock(entry_lock),
        .pol_lockdown(pol_lockdown), .pol_whitelist(pol_whitelist),
        .pol_bypass(pol_bypass)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; csr_we = 1'b0; entry_lock = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present a write at a falling edge; sample after the next falling edge
    task automatic do_write(input logic [11:0] a, input logic [1:0] p,
                            input logic we, input logic [31:0] d,
                            input logic [15:0] lk);
        @(negedge clk);
        csr_addr = a; csr_priv = p; csr_we = we; csr_wdata = d; entry_lock = lk;
        @(negedge clk);
        csr_we = 1'b0; entry_lock = '0;
    endtask

    function automatic int outs();
        return {29'd0, pol_bypass, pol_whitelist, pol_lockdown};
    endfunction

    task automatic read_main(output int v);
        csr_addr = 12'h747; csr_priv = 2'b11;
        #1 v = int'(csr_rdata);
    endtask

    initial begin
        int v;
        logic [11:0] alist [6] = '{12'h747, 12'h757, 12'h746, 12'h748, 12'h347, 12'h000};

        do_reset();
        @(negedge clk);
        read_main(v);
        chk("R1 reset outputs", outs(), 0);
        chk("R1 reset read", v, 0);

        // R8 decode sweep over addresses and privileges
        foreach (alist[i]) begin
            for (int p = 0; p < 4; p++) begin
                csr_addr = alist[i]; csr_priv = 2'(p);
                #1;
                chk("R8 defined", int'(csr_defined),
                    int'(p == 3 && (alist[i] == 12'h747 || alist[i] == 12'h757)));
                if (alist[i] != 12'h747) chk("R7 R2 nonmain read zero", int'(csr_rdata), 0);
            end
        end

        // Main sweep: start state, write data, lock pattern
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
                for (int lk = 0; lk < 2; lk++) begin
                    logic [15:0] lv;
                    int exp;
                    do_reset();
                    do_write(12'h747, 2'b11, 1'b1, 32'(s), 16'h0);
                    chk("R2 start write", outs(), s);
                    lv = (lk != 0) ? (16'h1 << ((s * 8 + d) % 16)) : 16'h0;
                    do_write(12'h747, 2'b11, 1'b1, 32'(d), lv);
                    exp = (s | d) & 3;
                    exp = exp | (((s & 4) != 0 || ((d & 4) != 0 && lv == 0)) ? 4 : 0);
                    chk("R3 R4 R5 R6 sticky outputs", outs(), exp);
                    read_main(v);
                    chk("R2 read fields", v, exp);
                    csr_addr = 12'h757;
                    #1 chk("R7 upper read", int'(csr_rdata), 0);
                end
            end
        end

        // R5 each single lock bit blocks bypass, then clear locks allow it
        for (int i = 0; i < 16; i++) begin
            do_reset();
            do_write(12'h747, 2'b11, 1'b1, 32'h4, 16'h1 << i);
            chk("R5 locked entry blocks bypass", int'(pol_bypass), 0);
            do_write(12'h747, 2'b11, 1'b1, 32'h4, 16'h0);
            chk("R5 unlocked sets bypass", int'(pol_bypass), 1);
        end

        // R7 upper-half writes ignored
        do_reset();
        do_write(12'h757, 2'b11, 1'b1, 32'hFFFF_FFFF, 16'h0);
        chk("R7 upper write ignored", outs(), 0);

        // R2 upper data bits ignored
        do_write(12'h747, 2'b11, 1'b1, 32'hFFFF_FFF8, 16'h0);
        chk("R2 upper data ignored", outs(), 0);

        // R9 non-machine, no-enable and wrong-address writes
        for (int p = 0; p < 3; p++) begin
            do_write(12'h747, 2'(p), 1'b1, 32'h7, 16'h0);
            chk("R9 low privilege write", outs(), 0);
        end
        do_write(12'h747, 2'b11, 1'b0, 32'h7, 16'h0);
        chk("R9 no enable", outs(), 0);
        do_write(12'h746, 2'b11, 1'b1, 32'h7, 16'h0);
        chk("R9 wrong address", outs(), 0);

        // R10 no change before the edge, change after it
        @(negedge clk);
        csr_addr = 12'h747; csr_priv = 2'b11; csr_we = 1'b1; csr_wdata = 32'h3;
        #1 chk("R10 before edge", outs(), 0);
        chk("R10 read before edge", int'(csr_rdata), 0);
        @(negedge clk);
        csr_we = 1'b0;
        chk("R10 after edge", outs(), 3);
        #1 chk("R10 read after edge", int'(csr_rdata), 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule